// File: doc/BRIEF.md
# Controller Event Packet Decoder

This block sits behind the byte transport of a power-management controller link and interprets each event packet that the transport has gathered. The packet arrives as a parallel byte buffer with a length and a one-cycle valid strobe. The first byte carries flag bits that pick a route. Peripheral-bus traffic goes either to a request that is parked waiting for an asynchronous answer or to an unsolicited input stream. A packet that is neither is checked for a front-panel button event.

A button event yields a backlight level and a volume byte. The level is turned into a controller brightness code through a nonlinear mapping, in which level zero selects a dedicated "dark" code. A matching backlight power command comes with it, and both commands are held back while the backlight is disabled. The block also keeps two status bits. One records a pending controller interrupt and is cleared by an empty packet. The other is a sleep marker that any packet clears.

Every result is registered. Each strobe appears exactly one clock after the packet strobe and lasts one cycle, and its data is valid during that cycle.

Top module: `evt_packet_decoder`

## Requirements
- R1: A packet of length 0 produces no reply, stream, error, brightness, power or volume strobe, and it clears `int_pending` unless `irq_note` is high in the same cycle (`irq_note` sets `int_pending`).
- R2: A non-empty packet whose byte 0 has the bus bit (bit 4, 0x10) set and the autopoll bit (bit 2, 0x04) clear is a reply. When `req_parked` is high it raises `reply_valid` for one cycle.
- R3: For a reply, a packet length of 2 or less gives `reply_len` 0 and all-zero `reply_data`. A longer packet gives `reply_len` equal to the length minus one, with packet byte k+1 at `reply_data` byte k (bits 8k+7..8k) and zero in the bytes past the length.
- R4: A reply-type packet that arrives while `req_parked` is low raises `err_extra_reply` for one cycle and raises no `reply_valid`.
- R5: A non-empty packet with both the bus bit and the autopoll bit set raises `stream_valid` whatever the value of `req_parked`. It gives `stream_len` equal to the length minus one, with packet byte k+1 at `stream_data` byte k and zero in the bytes past the length.
- R6: A packet with the bus bit clear, byte 0 equal to 0x08 and a length of exactly 3 is a button event. `bright_level` takes byte 1 shifted right by 3, and `vol_valid` pulses with `volume` equal to byte 2.
- R7: For a button event, `bright_code` is 0x7F when the level is 0 and 0x4A minus twice the level otherwise.
- R8: While `bl_enable` is high, a button event pulses `bright_valid` and `power_valid` together, with `power_on` high exactly when `bright_code` is below 0x7F. While `bl_enable` is low neither strobe pulses, but `bright_level` and the volume output still update.
- R9: A packet that matches none of the above (for example 0x08 with a length other than 3, or a bus-bit-clear byte 0 other than 0x08) raises no strobe and leaves `bright_level` unchanged.
- R10: `sleep_enter` sets `asleep`, and any packet strobe (including an empty packet) clears it. A packet strobe wins over `sleep_enter` in the same cycle.
- R11: Every output strobe is high only in the cycle after the packet strobe that caused it. Packets on consecutive cycles each produce their own strobes.
- R12: A length above MAX_BYTES is treated as MAX_BYTES.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pkt_valid | input | 1 | Packet present this cycle |
| pkt_len | input | LEN_W | Packet length in bytes |
| pkt_data | input | 8*MAX_BYTES | Packet bytes, byte i at bits 8i+7..8i |
| req_parked | input | 1 | A request is waiting for an asynchronous reply |
| bl_enable | input | 1 | Backlight commands permitted |
| irq_note | input | 1 | Controller interrupt seen, sets int_pending |
| sleep_enter | input | 1 | Sets the asleep marker |
| reply_valid | output | 1 | Reply delivered to the parked request |
| reply_len | output | LEN_W | Reply length |
| reply_data | output | 8*(MAX_BYTES-1) | Reply bytes |
| stream_valid | output | 1 | Unsolicited input delivered |
| stream_len | output | LEN_W | Input length |
| stream_data | output | 8*(MAX_BYTES-1) | Input bytes |
| err_extra_reply | output | 1 | Reply arrived with nothing parked |
| bright_valid | output | 1 | Brightness command strobe |
| bright_code | output | 8 | Controller brightness code |
| power_valid | output | 1 | Backlight power command strobe |
| power_on | output | 1 | Backlight power on (1) or off (0) |
| vol_valid | output | 1 | Volume update strobe |
| volume | output | 8 | Volume value |
| bright_level | output | 8-LVL_SHIFT | Last decoded brightness level |
| asleep | output | 1 | Sleep marker |
| int_pending | output | 1 | Pending-interrupt flag |

## Verification
The bench builds the decoder with MAX_BYTES set to 6, so the 3-bit length field can carry the value 7. That makes the clamp to capacity reachable, and with it the case where the last payload byte sits at the top of the output buffer. The flag-bit positions, the button tag and the level shift keep their defaults, so the level extremes 0 and 31 hit both the dark code and the smallest code.

// File: rtl/evtdec_pkg.sv
package evtdec_pkg;

  typedef enum logic [2:0] {
    PK_NONE,
    PK_EMPTY,
    PK_REPLY,
    PK_ORPHAN,
    PK_STREAM,
    PK_BUTTON
  } pkt_kind_e;

  // Level to controller brightness code; level 0 selects the dark code.
  function automatic logic [7:0] level_to_code(input logic [7:0] lvl);
    if (lvl == 8'd0) return 8'h7F;
    return 8'h4A - (lvl << 1);
  endfunction

  function automatic logic code_powers_on(input logic [7:0] code);
    return code < 8'h7F;
  endfunction

endpackage

// File: rtl/evtdec_classify.sv
module evtdec_classify
  import evtdec_pkg::*;
#(
  parameter int          MAX_BYTES  = 8,
  parameter int          LEN_W      = 4,
  parameter int          BUS_BIT    = 4,
  parameter int          AUTO_BIT   = 2,
  parameter logic [7:0]  BUTTON_TAG = 8'h08
) (
  input  logic [LEN_W-1:0] len_raw,
  input  logic [7:0]       byte0,
  input  logic             req_parked,
  output logic [LEN_W-1:0] len_eff,
  output pkt_kind_e        kind
);
  localparam logic [LEN_W-1:0] MAX_L    = LEN_W'(MAX_BYTES);
  localparam logic [LEN_W-1:0] BTN_LEN  = LEN_W'(3);

  always_comb begin
    len_eff = (len_raw > MAX_L) ? MAX_L : len_raw;
    if (len_eff == '0)
      kind = PK_EMPTY;
    else if (byte0[BUS_BIT])
      kind = byte0[AUTO_BIT] ? PK_STREAM : (req_parked ? PK_REPLY : PK_ORPHAN);
    else if (byte0 == BUTTON_TAG && len_eff == BTN_LEN)
      kind = PK_BUTTON;
    else
      kind = PK_NONE;
  end
endmodule

// File: rtl/evtdec_route.sv
module evtdec_route
  import evtdec_pkg::*;
#(
  parameter int MAX_BYTES = 8,
  parameter int LEN_W     = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       fire,
  input  pkt_kind_e                  kind,
  input  logic [LEN_W-1:0]           len_eff,
  input  logic [8*MAX_BYTES-1:0]     data,
  output logic                       reply_valid,
  output logic [LEN_W-1:0]           reply_len,
  output logic [8*(MAX_BYTES-1)-1:0] reply_data,
  output logic                       stream_valid,
  output logic [LEN_W-1:0]           stream_len,
  output logic [8*(MAX_BYTES-1)-1:0] stream_data,
  output logic                       err_extra
);
  localparam int PAY_BYTES = MAX_BYTES - 1;

  logic [8*PAY_BYTES-1:0] payload;
  logic [LEN_W-1:0]       pay_len;
  logic [LEN_W-1:0]       rep_len;
  logic                   take_reply, take_stream, take_orphan;

  // Payload = bytes 1 onward, zero past the packet length.
  for (genvar j = 0; j < PAY_BYTES; j++) begin : g_pay
    assign payload[8*j +: 8] = (LEN_W'(j + 1) < len_eff) ? data[8*(j+1) +: 8] : 8'h00;
  end

  assign pay_len     = len_eff - 1'b1;
  assign rep_len     = (len_eff <= LEN_W'(2)) ? '0 : pay_len;
  assign take_reply  = fire && (kind == PK_REPLY);
  assign take_stream = fire && (kind == PK_STREAM);
  assign take_orphan = fire && (kind == PK_ORPHAN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reply_valid  <= 1'b0;
      reply_len    <= '0;
      reply_data   <= '0;
      stream_valid <= 1'b0;
      stream_len   <= '0;
      stream_data  <= '0;
      err_extra    <= 1'b0;
    end else begin
      reply_valid  <= take_reply;
      stream_valid <= take_stream;
      err_extra    <= take_orphan;
      if (take_reply) begin
        reply_len  <= rep_len;
        reply_data <= (rep_len == '0) ? '0 : payload;
      end
      if (take_stream) begin
        stream_len  <= pay_len;
        stream_data <= payload;
      end
    end
  end

  // R3: a delivered reply is either empty or carries at least two bytes
  assert_reply_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    reply_valid |-> (reply_len != LEN_W'(1)))
    else $error("reply length of one delivered");

  // R12: stream length never exceeds the payload capacity
  assert_stream_cap_R12: assert property (@(posedge clk) disable iff (!rst_n)
    stream_valid |-> (stream_len <= LEN_W'(PAY_BYTES)))
    else $error("stream length above capacity");

  // R11: a route strobe follows a packet strobe
  assert_route_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (reply_valid || stream_valid || err_extra) |-> $past(fire))
    else $error("route strobe without packet");
endmodule

// File: rtl/evtdec_button.sv
module evtdec_button
  import evtdec_pkg::*;
#(
  parameter int LVL_SHIFT = 3,
  parameter int LVL_W     = 8 - LVL_SHIFT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic             is_button,
  input  logic [7:0]       byte1,
  input  logic [7:0]       byte2,
  input  logic             bl_enable,
  output logic [LVL_W-1:0] level,
  output logic             bright_valid,
  output logic [7:0]       bright_code,
  output logic             power_valid,
  output logic             power_on,
  output logic             vol_valid,
  output logic [7:0]       volume
);
  logic [7:0] new_level;
  logic [7:0] new_code;
  logic       hit;

  assign hit       = fire && is_button;
  assign new_level = byte1 >> LVL_SHIFT;
  assign new_code  = level_to_code(new_level);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      level        <= '0;
      bright_valid <= 1'b0;
      bright_code  <= 8'h7F;
      power_valid  <= 1'b0;
      power_on     <= 1'b0;
      vol_valid    <= 1'b0;
      volume       <= 8'h00;
    end else begin
      bright_valid <= hit && bl_enable;
      power_valid  <= hit && bl_enable;
      vol_valid    <= hit;
      if (hit) begin
        level  <= new_level[LVL_W-1:0];
        volume <= byte2;
        if (bl_enable) begin
          bright_code <= new_code;
          power_on    <= code_powers_on(new_code);
        end
      end
    end
  end

  // R8: commands only while the backlight is enabled
  assert_bright_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bright_valid || power_valid) |-> $past(bl_enable))
    else $error("backlight command while disabled");

  // R8: power and brightness commands travel together and agree
  assert_power_pair_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bright_valid |-> (power_valid && (power_on == (bright_code != 8'h7F))))
    else $error("power command disagrees with brightness code");

  // R7: the dark code belongs to level zero only
  assert_dark_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bright_valid |-> ((bright_code == 8'h7F) == (level == '0)))
    else $error("dark code mismatch");
endmodule

// File: rtl/evt_packet_decoder.sv
module evt_packet_decoder
  import evtdec_pkg::*;
#(
  parameter int         MAX_BYTES  = 8,
  parameter int         LEN_W      = $clog2(MAX_BYTES + 1),
  parameter int         BUS_BIT    = 4,
  parameter int         AUTO_BIT   = 2,
  parameter logic [7:0] BUTTON_TAG = 8'h08,
  parameter int         LVL_SHIFT  = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       pkt_valid,
  input  logic [LEN_W-1:0]           pkt_len,
  input  logic [8*MAX_BYTES-1:0]     pkt_data,
  input  logic                       req_parked,
  input  logic                       bl_enable,
  input  logic                       irq_note,
  input  logic                       sleep_enter,
  output logic                       reply_valid,
  output logic [LEN_W-1:0]           reply_len,
  output logic [8*(MAX_BYTES-1)-1:0] reply_data,
  output logic                       stream_valid,
  output logic [LEN_W-1:0]           stream_len,
  output logic [8*(MAX_BYTES-1)-1:0] stream_data,
  output logic                       err_extra_reply,
  output logic                       bright_valid,
  output logic [7:0]                 bright_code,
  output logic                       power_valid,
  output logic                       power_on,
  output logic                       vol_valid,
  output logic [7:0]                 volume,
  output logic [7-LVL_SHIFT:0]       bright_level,
  output logic                       asleep,
  output logic                       int_pending
);
  localparam int LVL_W = 8 - LVL_SHIFT;

  pkt_kind_e        kind;
  logic [LEN_W-1:0] len_eff;
  logic             is_button;
  logic             empty_pkt;

  evtdec_classify #(
    .MAX_BYTES(MAX_BYTES), .LEN_W(LEN_W), .BUS_BIT(BUS_BIT),
    .AUTO_BIT(AUTO_BIT), .BUTTON_TAG(BUTTON_TAG)
  ) classify_i (
    .len_raw(pkt_len), .byte0(pkt_data[7:0]), .req_parked(req_parked),
    .len_eff(len_eff), .kind(kind)
  );

  evtdec_route #(.MAX_BYTES(MAX_BYTES), .LEN_W(LEN_W)) route_i (
    .clk(clk), .rst_n(rst_n), .fire(pkt_valid), .kind(kind), .len_eff(len_eff),
    .data(pkt_data),
    .reply_valid(reply_valid), .reply_len(reply_len), .reply_data(reply_data),
    .stream_valid(stream_valid), .stream_len(stream_len), .stream_data(stream_data),
    .err_extra(err_extra_reply)
  );

  assign is_button = (kind == PK_BUTTON);
  assign empty_pkt = pkt_valid && (kind == PK_EMPTY);

  evtdec_button #(.LVL_SHIFT(LVL_SHIFT), .LVL_W(LVL_W)) button_i (
    .clk(clk), .rst_n(rst_n), .fire(pkt_valid), .is_button(is_button),
    .byte1(pkt_data[15:8]), .byte2(pkt_data[23:16]), .bl_enable(bl_enable),
    .level(bright_level), .bright_valid(bright_valid), .bright_code(bright_code),
    .power_valid(power_valid), .power_on(power_on),
    .vol_valid(vol_valid), .volume(volume)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      asleep      <= 1'b0;
      int_pending <= 1'b0;
    end else begin
      if (pkt_valid)        asleep <= 1'b0;
      else if (sleep_enter) asleep <= 1'b1;
      if (irq_note)         int_pending <= 1'b1;
      else if (empty_pkt)   int_pending <= 1'b0;
    end
  end

  // R1: an empty packet without a fresh interrupt leaves nothing pending
  assert_empty_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pkt_valid && pkt_len == '0 && !irq_note) |-> !int_pending)
    else $error("pending flag survived empty packet");

  // R2: replies only reach a parked request
  assert_reply_parked_R2: assert property (@(posedge clk) disable iff (!rst_n)
    reply_valid |-> $past(req_parked))
    else $error("reply without parked request");

  // R4: the extra-reply error only when nothing was parked
  assert_orphan_R4: assert property (@(posedge clk) disable iff (!rst_n)
    err_extra_reply |-> (!$past(req_parked) && !reply_valid))
    else $error("extra-reply error with parked request");

  // R10: any packet clears the sleep marker
  assert_asleep_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pkt_valid) |-> !asleep)
    else $error("asleep survived a packet");
endmodule

// File: tb/evt_packet_decoder_tb_top.sv
module evt_packet_decoder_tb_top;
  localparam int MAXB  = 6;
  localparam int LW    = 3;
  localparam int PAYW  = 8 * (MAXB - 1);

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            pkt_valid = 1'b0;
  logic [LW-1:0]   pkt_len = '0;
  logic [8*MAXB-1:0] pkt_data = '0;
  logic            req_parked = 1'b0;
  logic            bl_enable = 1'b0;
  logic            irq_note = 1'b0;
  logic            sleep_enter = 1'b0;
  logic            reply_valid, stream_valid, err_extra_reply;
  logic [LW-1:0]   reply_len, stream_len;
  logic [PAYW-1:0] reply_data, stream_data;
  logic            bright_valid, power_valid, power_on, vol_valid, asleep, int_pending;
  logic [7:0]      bright_code, volume;
  logic [4:0]      bright_level;

  int runs = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  evt_packet_decoder #(.MAX_BYTES(MAXB), .LEN_W(LW)) dut_i (
    .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .pkt_len(pkt_len),
    .pkt_data(pkt_data), .req_parked(req_parked), .bl_enable(bl_enable),
    .irq_note(irq_note), .sleep_enter(sleep_enter),
    .reply_valid(reply_valid), .reply_len(reply_len), .reply_data(reply_data),
    .stream_valid(stream_valid), .stream_len(stream_len), .stream_data(stream_data),
    .err_extra_reply(err_extra_reply), .bright_valid(bright_valid),
    .bright_code(bright_code), .power_valid(power_valid), .power_on(power_on),
    .vol_valid(vol_valid), .volume(volume), .bright_level(bright_level),
    .asleep(asleep), .int_pending(int_pending)
  );

  task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
    runs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  function automatic logic [8*MAXB-1:0] pk(input logic [7:0] b0, b1, b2, b3, b4, b5);
    return {b5, b4, b3, b2, b1, b0};
  endfunction

  function automatic logic [7:0] strobes();
    return {1'b0, reply_valid, stream_valid, err_extra_reply,
            bright_valid, power_valid, vol_valid, 1'b0};
  endfunction

  // Drive one packet, return at the negedge after the capturing edge.
  task automatic send(input logic [LW-1:0] len, input logic [8*MAXB-1:0] d);
    @(negedge clk);
    pkt_valid = 1'b1; pkt_len = len; pkt_data = d;
    @(negedge clk);
    pkt_valid = 1'b0; pkt_len = '0; pkt_data = '0;
  endtask

  task automatic t_reset();
    chk("R11 reset strobes", strobes(), 8'h00);
    chk("R10 reset asleep", asleep, 0);
    chk("R1 reset pending", int_pending, 0);
    chk("R6 reset level", bright_level, 0);
  endtask

  task automatic t_empty();
    @(negedge clk); irq_note = 1'b1; sleep_enter = 1'b1;
    @(negedge clk); irq_note = 1'b0; sleep_enter = 1'b0;
    chk("R1 pending set", int_pending, 1);
    chk("R10 asleep set", asleep, 1);
    send(0, pk(8'h10, 8'h11, 0, 0, 0, 0));
    chk("R1 empty no strobes", strobes(), 8'h00);
    chk("R1 empty clears pending", int_pending, 0);
    chk("R10 packet clears asleep", asleep, 0);
  endtask

  task automatic t_reply();
    req_parked = 1'b1;
    send(5, pk(8'h10, 8'hAA, 8'hBB, 8'hCC, 8'hDD, 8'hEE));
    chk("R2 reply strobe", reply_valid, 1);
    chk("R2 no stream", stream_valid, 0);
    chk("R3 reply len", reply_len, 4);
    chk("R3 reply data", reply_data, 40'h00DDCCBBAA);
    send(2, pk(8'h10, 8'h77, 8'h66, 0, 0, 0));
    chk("R3 short reply strobe", reply_valid, 1);
    chk("R3 short reply len", reply_len, 0);
    chk("R3 short reply data", reply_data, 0);
  endtask

  task automatic t_orphan();
    req_parked = 1'b0;
    send(3, pk(8'h10, 8'h01, 8'h02, 0, 0, 0));
    chk("R4 error strobe", err_extra_reply, 1);
    chk("R4 no reply", reply_valid, 0);
  endtask

  task automatic t_stream();
    req_parked = 1'b1;
    send(4, pk(8'h14, 8'h01, 8'h02, 8'h03, 8'h09, 8'h09));
    chk("R5 stream strobe", stream_valid, 1);
    chk("R5 no reply", reply_valid, 0);
    chk("R5 stream len", stream_len, 3);
    chk("R5 stream data", stream_data, 40'h0000030201);
    req_parked = 1'b0;
    send(7, pk(8'h14, 8'hA1, 8'hA2, 8'hA3, 8'hA4, 8'hA5));
    chk("R12 clamped strobe", stream_valid, 1);
    chk("R12 clamped len", stream_len, 5);
    chk("R12 clamped data", stream_data, 40'hA5A4A3A2A1);
  endtask

  task automatic t_button();
    bl_enable = 1'b1;
    send(3, pk(8'h08, 8'h50, 8'h33, 0, 0, 0));
    chk("R6 level", bright_level, 10);
    chk("R6 volume strobe", vol_valid, 1);
    chk("R6 volume", volume, 8'h33);
    chk("R7 code lvl10", bright_code, 8'h36);
    chk("R8 bright strobe", bright_valid, 1);
    chk("R8 power strobe", power_valid, 1);
    chk("R8 power on", power_on, 1);
    send(3, pk(8'h08, 8'h07, 8'h01, 0, 0, 0));
    chk("R7 code lvl0", bright_code, 8'h7F);
    chk("R8 power off", power_on, 0);
    chk("R6 level zero", bright_level, 0);
    send(3, pk(8'h08, 8'hF8, 8'h02, 0, 0, 0));
    chk("R7 code lvl31", bright_code, 8'h0C);
    bl_enable = 1'b0;
    send(3, pk(8'h08, 8'h28, 8'h44, 0, 0, 0));
    chk("R8 disabled no bright", bright_valid, 0);
    chk("R8 disabled no power", power_valid, 0);
    chk("R8 disabled level updates", bright_level, 5);
    chk("R8 disabled volume", {7'd0, vol_valid, volume}, {7'd0, 1'b1, 8'h44});
  endtask

  task automatic t_other();
    bl_enable = 1'b1;
    send(4, pk(8'h08, 8'hF0, 8'h01, 8'h02, 0, 0));
    chk("R9 wrong length no strobes", strobes(), 8'h00);
    chk("R9 level unchanged", bright_level, 5);
    send(2, pk(8'h20, 8'h55, 0, 0, 0, 0));
    chk("R9 unknown tag no strobes", strobes(), 8'h00);
  endtask

  task automatic t_b2b();
    req_parked = 1'b1;
    @(negedge clk);
    pkt_valid = 1'b1; pkt_len = 3; pkt_data = pk(8'h10, 8'h21, 8'h22, 0, 0, 0);
    @(negedge clk);
    chk("R11 first reply", reply_valid, 1);
    chk("R11 first len", reply_len, 2);
    pkt_len = 2; pkt_data = pk(8'h14, 8'h31, 0, 0, 0, 0);
    @(negedge clk);
    pkt_valid = 1'b0; pkt_len = '0; pkt_data = '0;
    chk("R11 second stream", stream_valid, 1);
    chk("R11 reply dropped", reply_valid, 0);
    chk("R11 second data", stream_data, 40'h31);
    @(negedge clk);
    chk("R11 pulses end", strobes(), 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_empty();
    t_reply();
    t_orphan();
    t_stream();
    t_button();
    t_other();
    t_b2b();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      runs++;
      fails++;
      $display("FAIL R11 watchdog expired actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", runs, fails);
      $finish;
    end
  end
endmodule